// File: doc/BRIEF.md
# Powered-Device Classification Sequencer

This block runs powered-device classification for a group of Ethernet power ports. There is one sequencer per port. A start pulse makes the sequencer ask the analog front end to drive the port at the probe level. It counts the probe window on a slow millisecond tick. On the final tick of the window it samples a digitized class current in milliamps and converts it to a class code from 0 to 5. Class 5 is an extended class above the standard ones. Currents that fall between two standard bands go to the higher class.

A port whose repeat-enable input is high when its start is accepted runs three classification cycles. Between cycles the port is held at a reduced mark level for a fixed number of ticks instead of being released. After every cycle the port's done event bit is set and its class status field takes the new result, so when the sequence ends the status holds the last result.

A small read port serves the results. One address returns the event bits with no side effect. A second address returns the same bits and clears them. Further addresses return each port's class status. A port power-down pulse clears that port's event bit. A port reset also aborts the port's sequence and zeroes its status.

Top module: `pdclass_ctrl`

## Requirements
- R1: A start pulse on an idle port raises that port's probe request on the next cycle. The request stays high for PROBE_TICKS ticks (default 10) and drops on the cycle after the last of them.
- R2: The class code is 0 for currents 0..5, 1 for 6..13, 2 for 14..21, 3 for 22..31, 4 for 32..45 and 5 (3'b101) for 46 and above. The current input is 8 bits per port, port p at bits [8p+7:8p], 1 LSB = 1 mA.
- R3: When a classification cycle ends, the port's done bit is set and its class status is loaded with the decode of the current sampled on the final tick.
- R4: A read of address 1 returns the event bits in rd_data[3:0] (bit p = port p) on the next cycle and clears them. A read of address 0 returns the same bits and does not clear them. A read of address 2+p returns port p's class in rd_data[2:0]. rd_data holds its value while no read is made.
- R5: If a cycle ends in the same clock as a clearing read, the done bit stays set and the read data shows the value before the cycle ended.
- R6: With repeat enabled at start, the port runs exactly three probe windows. Each pair is separated by WAIT_TICKS ticks (default 8) with the mark request high and the probe request low.
- R7: After a repeated sequence the class status holds the result of the third cycle.
- R8: A start pulse on a port that is probing or holding has no effect on that port's sequence.
- R9: A power-down pulse on a port clears only that port's done bit.
- R10: A port reset returns that port to idle on the next cycle, drops both level requests, clears its done bit and sets its status to 0.
- R11: After system reset, all level requests are low, and the event bits and all status fields read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 1 kHz |
| start | input | NPORTS | Per-port classification start pulse |
| multi_en | input | NPORTS | Per-port repeat (three-cycle) enable, sampled at start |
| pwr_down | input | NPORTS | Per-port power-down pulse, clears the event bit |
| port_rst | input | NPORTS | Per-port reset pulse |
| icls_code | input | NPORTS*CODE_W | Per-port digitized class current in mA |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| probe_req | output | NPORTS | Per-port request to drive the probe level |
| mark_req | output | NPORTS | Per-port request to hold the mark level |
| rd_data | output | DATA_W | Registered read data |

## Verification
The sensitive coincidence is the end of a classification cycle, which sets a done bit, falling in the same clock as a clearing read of the event register. The bench waits until port 0 is one probe tick from the end of its window. It then issues a clearing read on every clock until well after the cycle ends. The bit must appear in exactly one read reply: the reply after the end, never the one captured in the same clock. A behavioural model run on every clock judges each reply.

// File: rtl/pdc_pkg.sv
// Package: shared constants and types for the classification sequencer.
// Assumes: read addresses 0 and 1 hold the event bits, 2.. hold per-port status.
package pdc_pkg;
    localparam int CLS_W     = 3;
    localparam int ADR_EV    = 0;
    localparam int ADR_EV_RC = 1;
    localparam int ADR_STAT0 = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_HOLD  = 2'd2
    } pdc_state_e;
endpackage

// File: rtl/pdc_class_dec.sv
// Module: converts a digitized class current (mA) into a class code 0..5.
// Assumes: thresholds are the lower edges of the gap regions, so each gap
// resolves to the higher class; the code is combinational.
module pdc_class_dec
    import pdc_pkg::*;
#(
    parameter int unsigned CODE_W = 8,
    parameter logic [CODE_W-1:0] TH1 = 6,
    parameter logic [CODE_W-1:0] TH2 = 14,
    parameter logic [CODE_W-1:0] TH3 = 22,
    parameter logic [CODE_W-1:0] TH4 = 32,
    parameter logic [CODE_W-1:0] TH5 = 46
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CLS_W-1:0]  cls_o
);
    // threshold ladder: highest band reached wins
    always_comb begin
        if      (code_i >= TH5) cls_o = 3'd5;
        else if (code_i >= TH4) cls_o = 3'd4;
        else if (code_i >= TH3) cls_o = 3'd3;
        else if (code_i >= TH2) cls_o = 3'd2;
        else if (code_i >= TH1) cls_o = 3'd1;
        else                    cls_o = 3'd0;
    end
endmodule

// File: rtl/pdc_port_seq.sv
// Module: per-port classification sequencer. Probes for PROBE_TICKS ticks,
// optionally repeats NUM_EVENTS times with WAIT_TICKS-tick mark holds between.
// Assumes: tick is a one-cycle pulse; port_rst overrides everything.
module pdc_port_seq
    import pdc_pkg::*;
#(
    parameter int unsigned PROBE_TICKS = 10,
    parameter int unsigned WAIT_TICKS  = 8,
    parameter int unsigned NUM_EVENTS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic multi_en,
    input  logic port_rst,
    output logic probe_o,
    output logic mark_o,
    output logic cyc_done_o
);
    localparam int unsigned CNT_MAX = (PROBE_TICKS > WAIT_TICKS) ? PROBE_TICKS : WAIT_TICKS;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned REM_W   = $clog2(NUM_EVENTS + 1);

    pdc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [REM_W-1:0] rem;
    logic             probe_last;
    logic             hold_last;

    // last tick of the current probe or hold window
    assign probe_last = tick && (cnt == CNT_W'(PROBE_TICKS - 1));
    assign hold_last  = tick && (cnt == CNT_W'(WAIT_TICKS - 1));
    assign cyc_done_o = (state == ST_PROBE) && probe_last && !port_rst;
    assign probe_o    = (state == ST_PROBE);
    assign mark_o     = (state == ST_HOLD);

    // state, tick counter and remaining-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || port_rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            rem   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_PROBE;
                    cnt   <= '0;
                    rem   <= multi_en ? REM_W'(NUM_EVENTS - 1) : '0;
                end
                ST_PROBE: if (tick) begin
                    if (probe_last) begin
                        cnt <= '0;
                        if (rem != '0) begin
                            state <= ST_HOLD;
                            rem   <= rem - 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: if (tick) begin
                    if (hold_last) begin
                        state <= ST_PROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a mark hold is only ever entered straight from a probe window
    p_mark_after_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mark_o) |-> $past(probe_o));

    // R1: a probe window closes only on a tick or a port reset
    p_probe_ends_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(probe_o) |-> $past(tick || port_rst));

    // R8: a start during a probe window leaves the sequence untouched
    p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_o && start && !tick && !port_rst) |=> (probe_o && $stable(rem) && $stable(cnt)));
endmodule

// File: rtl/pdc_regs.sv
// Module: per-port done event bits, class status fields and registered read port.
// Assumes: a cycle-done pulse outranks every clear except a port reset,
// which the sequencer already masks out of the done pulse.
module pdc_regs
    import pdc_pkg::*;
#(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS-1:0]       cyc_done,
    input  logic [NPORTS*CLS_W-1:0] cls_new,
    input  logic [NPORTS-1:0]       pwr_down,
    input  logic [NPORTS-1:0]       port_rst,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);
    logic [NPORTS-1:0] done;
    logic [CLS_W-1:0]  stat [NPORTS];
    logic [NPORTS-1:0] clr;
    logic [DATA_W-1:0] rd_nxt;

    // all clear sources for the event bits
    assign clr = pwr_down | port_rst |
                 ((rd_en && rd_addr == ADDR_W'(ADR_EV_RC)) ? {NPORTS{1'b1}} : '0);

    // event bits: set by a finished cycle, which beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) done <= '0;
        else        done <= (done & ~clr) | cyc_done;
    end

    // per-port class status storage
    for (genvar p = 0; p < NPORTS; p++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n || port_rst[p]) stat[p] <= '0;
            else if (cyc_done[p])      stat[p] <= cls_new[p*CLS_W +: CLS_W];
        end

        // R3: the status takes the decode presented when the cycle ended
        p_status_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cyc_done[p]) |-> (stat[p] == $past(cls_new[p*CLS_W +: CLS_W])));
    end

    // read multiplexer
    always_comb begin
        rd_nxt = '0;
        if (rd_addr == ADDR_W'(ADR_EV) || rd_addr == ADDR_W'(ADR_EV_RC))
            rd_nxt[NPORTS-1:0] = done;
        for (int i = 0; i < NPORTS; i++)
            if (rd_addr == ADDR_W'(ADR_STAT0 + i)) rd_nxt[CLS_W-1:0] = stat[i];
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_nxt;
    end

    // R5: a cycle that ends always leaves its event bit set
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & $past(cyc_done)) == $past(cyc_done)));

    // R9: a power-down without a same-cycle completion empties the bit
    p_pdown_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & $past(pwr_down & ~cyc_done)) == '0));

    // R4: the clearing read returns the bits as they stood before the clear
    p_rc_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && rd_addr == ADDR_W'(ADR_EV_RC)) |-> (rd_data[NPORTS-1:0] == $past(done)));
endmodule

// File: rtl/pdclass_ctrl.sv
// Module: top of the classification sequencer for NPORTS ports.
// Assumes: icls_code is stable around the final probe tick; tick is 1 kHz.
module pdclass_ctrl
    import pdc_pkg::*;
#(
    parameter int unsigned NPORTS      = 4,
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PROBE_TICKS = 10,
    parameter int unsigned WAIT_TICKS  = 8,
    parameter int unsigned NUM_EVENTS  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NPORTS-1:0]        start,
    input  logic [NPORTS-1:0]        multi_en,
    input  logic [NPORTS-1:0]        pwr_down,
    input  logic [NPORTS-1:0]        port_rst,
    input  logic [NPORTS*CODE_W-1:0] icls_code,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NPORTS-1:0]        probe_req,
    output logic [NPORTS-1:0]        mark_req,
    output logic [DATA_W-1:0]        rd_data
);
    logic [NPORTS-1:0]       cyc_done;
    logic [NPORTS*CLS_W-1:0] cls_all;

    // one sequencer and one decoder per port
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pdc_port_seq #(
            .PROBE_TICKS (PROBE_TICKS),
            .WAIT_TICKS  (WAIT_TICKS),
            .NUM_EVENTS  (NUM_EVENTS)
        ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .start      (start[p]),
            .multi_en   (multi_en[p]),
            .port_rst   (port_rst[p]),
            .probe_o    (probe_req[p]),
            .mark_o     (mark_req[p]),
            .cyc_done_o (cyc_done[p])
        );

        pdc_class_dec #(.CODE_W(CODE_W)) u_dec (
            .code_i (icls_code[p*CODE_W +: CODE_W]),
            .cls_o  (cls_all[p*CLS_W +: CLS_W])
        );
    end

    pdc_regs #(
        .NPORTS (NPORTS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_done (cyc_done),
        .cls_new  (cls_all),
        .pwr_down (pwr_down),
        .port_rst (port_rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/tb_pdclass_ctrl.sv
// Bench: behavioural reference model compared on every clock plus directed checks.
module tb_pdclass_ctrl;
    localparam int PT   = 10;
    localparam int WT   = 8;
    localparam int TDIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  start = '0, multi_en = '0, pwr_down = '0, port_rst = '0;
    logic [31:0] icls_code = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [3:0]  probe_req, mark_req;
    logic [7:0]  rd_data;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    bit tick_on = 0;
    int tdiv = 0;

    pdclass_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .multi_en(multi_en),
        .pwr_down(pwr_down), .port_rst(port_rst), .icls_code(icls_code),
        .rd_en(rd_en), .rd_addr(rd_addr), .probe_req(probe_req),
        .mark_req(mark_req), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R2 reference table, written from the band list
    function automatic int ref_class(int ma);
        if (ma >= 46) return 5;
        if (ma >= 32) return 4;
        if (ma >= 22) return 3;
        if (ma >= 14) return 2;
        if (ma >= 6)  return 1;
        return 0;
    endfunction

    // reference model state
    int m_st[4], m_cnt[4], m_rem[4], m_stat[4];
    bit [3:0] m_done;
    int m_rd;
    bit [3:0] ends, clrm;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) begin m_st[p] = 0; m_cnt[p] = 0; m_rem[p] = 0; m_stat[p] = 0; end
            m_done = 0; m_rd = 0;
        end else begin
            ends = 0;
            if (rd_en) begin
                if (rd_addr == 0 || rd_addr == 1) m_rd = m_done;
                else if (rd_addr >= 2 && rd_addr <= 5) m_rd = m_stat[rd_addr - 2];
                else m_rd = 0;
            end
            for (int p = 0; p < 4; p++) begin
                if (port_rst[p]) begin m_st[p] = 0; m_cnt[p] = 0; m_rem[p] = 0; end
                else if (m_st[p] == 0) begin
                    if (start[p]) begin m_st[p] = 1; m_cnt[p] = 0; m_rem[p] = multi_en[p] ? 2 : 0; end
                end else if (m_st[p] == 1) begin
                    if (tick) begin
                        if (m_cnt[p] == PT - 1) begin
                            ends[p] = 1; m_cnt[p] = 0;
                            if (m_rem[p] > 0) begin m_st[p] = 2; m_rem[p]--; end else m_st[p] = 0;
                        end else m_cnt[p]++;
                    end
                end else if (tick) begin
                    if (m_cnt[p] == WT - 1) begin m_st[p] = 1; m_cnt[p] = 0; end else m_cnt[p]++;
                end
            end
            clrm = pwr_down | port_rst | ((rd_en && rd_addr == 1) ? 4'hF : 4'h0);
            for (int p = 0; p < 4; p++) begin
                if (port_rst[p]) m_stat[p] = 0;
                else if (ends[p]) m_stat[p] = ref_class(int'(icls_code[p*8 +: 8]));
            end
            m_done = (m_done & ~clrm) | ends;
        end
    end

    // tick generator, driven away from the active edge
    always @(negedge clk) begin
        if (tick_on) begin
            tdiv = (tdiv + 1) % TDIV;
            tick <= (tdiv == 0);
        end else tick <= 1'b0;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int p = 0; p < 4; p++) begin
                chk("R1 probe level", probe_req[p], m_st[p] == 1);
                chk("R6 mark level", mark_req[p], m_st[p] == 2);
            end
            chk("R4 read data", rd_data, m_rd);
        end
    end

    task automatic rd(input int a, output int v);
        @(negedge clk); rd_en = 1; rd_addr = 3'(a);
        @(negedge clk); rd_en = 0; v = rd_data;
    endtask

    task automatic pulse_start(input logic [3:0] m, input logic [3:0] men);
        @(negedge clk); start = m; multi_en = men;
        @(negedge clk); start = 0;
    endtask

    task automatic set_code(int p, int v);
        icls_code[p*8 +: 8] = 8'(v);
    endtask

    // runs one single-cycle batch on all ports and checks the status
    task automatic batch(int c0, int c1, int c2, int c3);
        int v;
        set_code(0, c0); set_code(1, c1); set_code(2, c2); set_code(3, c3);
        pulse_start(4'hF, 4'h0);
        repeat (PT * TDIV + 10) @(negedge clk);
        rd(2, v); chk("R2 class port0", v, ref_class(c0));
        rd(3, v); chk("R2 class port1", v, ref_class(c1));
        rd(4, v); chk("R2 class port2", v, ref_class(c2));
        rd(5, v); chk("R3 class port3", v, ref_class(c3));
        rd(0, v); chk("R3 done bits", v, 15);
        rd(1, v); chk("R4 clearing read", v, 15);
        rd(0, v); chk("R4 bits cleared", v, 0);
    endtask

    initial begin
        int v, rises, seen;
        bit prev;
        repeat (4) @(negedge clk);
        rst_n = 1;
        tick_on = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 probe after reset", probe_req, 0);
        chk("R11 mark after reset", mark_req, 0);
        rd(0, v); chk("R11 events after reset", v, 0);
        rd(3, v); chk("R11 status after reset", v, 0);

        // R1 probe window length: rises next cycle, spans PT ticks
        set_code(0, 3);
        pulse_start(4'h1, 4'h0);
        chk("R1 probe raised", probe_req[0], 1);
        repeat (PT * TDIV + 10) @(negedge clk);
        chk("R1 probe dropped", probe_req[0], 0);
        rd(1, v);

        // R2 band edges, gaps to the higher class, Class 5 as 3'b101
        batch(3, 7, 13, 46);
        batch(14, 21, 22, 31);
        batch(32, 45, 5, 6);
        batch(0, 200, 8, 48);

        // R6 R7 R8 repeated sequence with start retries and a code change
        set_code(1, 20);
        pulse_start(4'h2, 4'h2);
        rises = 1; prev = 1;
        for (int i = 0; i < 240; i++) begin
            @(negedge clk);
            if (probe_req[1] && !prev) rises++;
            prev = probe_req[1];
            if (i == 10 || i == 60) start = 4'h2;   // R8 retries while busy
            else start = 0;
            if (i == 60) set_code(1, 40);
        end
        chk("R6 three probe windows", rises, 3);
        rd(3, v); chk("R7 last result kept", v, 4);
        rd(1, v); chk("R3 done after sequence", v, 2);

        // R5 cycle end meeting a clearing read
        set_code(0, 25);
        pulse_start(4'h1, 4'h0);
        while (!(m_st[0] == 1 && m_cnt[0] == PT - 1)) @(negedge clk);
        seen = 0;
        rd_addr = 1; rd_en = 1;
        for (int i = 0; i < 3 * TDIV + 4; i++) begin
            @(negedge clk);
            if (rd_data[0]) seen++;
        end
        rd_en = 0;
        chk("R5 bit reported exactly once", seen, 1);
        rd(2, v); chk("R5 status with clash", v, 3);

        // R9 power-down clears only its port
        batch(1, 1, 1, 1);
        pulse_start(4'hF, 4'h0);
        repeat (PT * TDIV + 10) @(negedge clk);
        pwr_down = 4'h4; @(negedge clk); pwr_down = 0;
        rd(0, v); chk("R9 only port2 cleared", v, 11);
        rd(1, v);

        // R10 port reset mid-sequence
        set_code(3, 50);
        pulse_start(4'h8, 4'h8);
        repeat (PT * TDIV + 20) @(negedge clk);
        chk("R10 in hold before reset", mark_req[3], 1);
        port_rst = 4'h8; @(negedge clk); port_rst = 0;
        chk("R10 levels dropped", {probe_req[3], mark_req[3]}, 0);
        repeat (100) @(negedge clk);
        chk("R10 stays idle", probe_req[3], 0);
        rd(5, v); chk("R10 status zero", v, 0);
        rd(0, v); chk("R10 done cleared", v, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end
endmodule